// File: doc/BRIEF.md
# Dual Event Counter Unit

This block is the counting core of a processor performance monitor. It holds two 32-bit event counters and one shared control register. Each counter has its own event-select field and picks one line from a vector of single-cycle event pulses. Both counters read and write together through one 64-bit counter register. Counting is qualified by three shared privilege enables (user, supervisor, hypervisor), so the counters cannot be started or stopped one at a time.

To idle one counter while the other keeps running, software writes an event code that lies outside the implemented event vector into that counter's field. The code 0x220 is reserved for this purpose. When a counter wraps from all ones to zero, it sets its own sticky flag in the control register. This tells software which counter overflowed, even one it considers unused. A level interrupt follows the flags when the interrupt enable is set. Software can preload a counter with the two's complement of a sample period, so that it overflows after exactly that many qualifying events.

Top module: `dual_evcnt_unit`

## Requirements
- R1: After reset, the control register and the counter register both read zero and `ovf_irq` is low.
- R2: The counter register holds the upper counter in bits 63:32 and the lower counter in bits 31:0. A write loads both halves and a read returns both halves.
- R3: Privilege input encoding: `priv` 0 is user, gated by control bit 2; 1 is supervisor, gated by bit 1; 2 is hypervisor, gated by bit 3; 3 never counts.
- R4: When all three privilege enables are clear, neither counter increments, whatever the event pulses do.
- R5: The upper counter's event-select field is control bits 30:19 and the lower counter's field is bits 17:6. A code below NUM_EVT (16 by default) selects `evt_pulse[code]`. The counter adds exactly one in each enabled cycle in which that line is high.
- R6: A code at or above NUM_EVT never fires, and this includes the park code 0x220. A parked counter holds its value while the other counter keeps counting.
- R7: An overflow happens only when a counter steps from 0xFFFFFFFF to 0. It sets that counter's sticky flag only: bit 34 for the upper counter, bit 33 for the lower counter.
- R8: A counter preloaded with the two's complement of P sets its flag on the P-th qualifying event and not before.
- R9: Writing 0 to a sticky flag bit clears it. Writing 1 to it leaves it unchanged. A flag set in the same cycle as a clearing write stays set.
- R10: `ovf_irq` is high exactly when control bit 0 (interrupt enable) is set and at least one sticky flag is set.
- R11: A counter-register write in the same cycle as an increment loads the written value. The increment is dropped, so no overflow is recorded for it.
- R12: Control read-back returns the enables (bits 3:0), both select fields and the flags. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv | input | 2 | Current privilege level (R3 encoding) |
| evt_pulse | input | NUM_EVT | Single-cycle event lines |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the counter register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register (combinational) |
| ovf_irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the unit with its default parameters: 32-bit counters, 12-bit select fields and a 16-line event vector. With 16 lines, every implemented event code can be swept one by one, together with the first out-of-range codes and the park code, on both counters.

All combinations of privilege level and enable mask are applied. The 32-bit width is made reachable by preloading values a few counts below the wrap point. This lets short runs cover the exact overflow cycle for several sample periods, and the collision of a write with an increment at the wrap point.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

   // Privilege levels as driven on the priv port.
   typedef enum logic [1:0] {
      PRIV_USER = 2'b00,
      PRIV_SUP  = 2'b01,
      PRIV_HYP  = 2'b10,
      PRIV_NONE = 2'b11
   } priv_e;

   // Control register bit positions that software decodes.
   localparam int unsigned IRQ_EN_BIT  = 0;
   localparam int unsigned SUP_EN_BIT  = 1;
   localparam int unsigned USER_EN_BIT = 2;
   localparam int unsigned HYP_EN_BIT  = 3;
   localparam int unsigned LO_FLAG_BIT = 33;
   localparam int unsigned UP_FLAG_BIT = 34;

   // Lane indices.
   localparam int unsigned LANE_LO = 0;
   localparam int unsigned LANE_UP = 1;
   localparam int unsigned N_LANES = 2;

endpackage

// File: rtl/evcnt_ctrl.sv
module evcnt_ctrl
   import evcnt_pkg::*;
#(
   parameter int unsigned REG_W      = 64,
   parameter int unsigned SEL_W      = 12,
   parameter int unsigned UP_SEL_LSB = 19,
   parameter int unsigned LO_SEL_LSB = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [REG_W-1:0]   wdata,
   input  logic [N_LANES-1:0] ovf,
   output logic               irq_en,
   output logic               en_user,
   output logic               en_sup,
   output logic               en_hyp,
   output logic [SEL_W-1:0]   sel_lo,
   output logic [SEL_W-1:0]   sel_up,
   output logic [N_LANES-1:0] flag,
   output logic [REG_W-1:0]   image
);

   localparam int unsigned EN_W = HYP_EN_BIT + 1;

   logic [EN_W-1:0]    en_q;
   logic [SEL_W-1:0]   sel_lo_q, sel_up_q;
   logic [N_LANES-1:0] flag_q;
   logic [N_LANES-1:0] keep_mask;
   wire                unused_wbits = ^wdata;

   // Writing 0 clears a flag, writing 1 keeps it; a new overflow always wins.
   always_comb begin
      keep_mask = '1;
      if (wr) begin
         keep_mask[LANE_LO] = wdata[LO_FLAG_BIT];
         keep_mask[LANE_UP] = wdata[UP_FLAG_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= '0;
         sel_lo_q <= '0;
         sel_up_q <= '0;
         flag_q   <= '0;
      end else begin
         if (wr) begin
            en_q     <= wdata[EN_W-1:0];
            sel_lo_q <= wdata[LO_SEL_LSB +: SEL_W];
            sel_up_q <= wdata[UP_SEL_LSB +: SEL_W];
         end
         flag_q <= (flag_q & keep_mask) | ovf;
      end
   end

   always_comb begin
      image                          = '0;
      image[EN_W-1:0]                = en_q;
      image[LO_SEL_LSB +: SEL_W]     = sel_lo_q;
      image[UP_SEL_LSB +: SEL_W]     = sel_up_q;
      image[LO_FLAG_BIT]             = flag_q[LANE_LO];
      image[UP_FLAG_BIT]             = flag_q[LANE_UP];
   end

   assign irq_en  = en_q[IRQ_EN_BIT];
   assign en_sup  = en_q[SUP_EN_BIT];
   assign en_user = en_q[USER_EN_BIT];
   assign en_hyp  = en_q[HYP_EN_BIT];
   assign sel_lo  = sel_lo_q;
   assign sel_up  = sel_up_q;
   assign flag    = flag_q;

endmodule

// File: rtl/evcnt_lane.sv
module evcnt_lane #(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned SEL_W   = 12,
   parameter int unsigned NUM_EVT = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt,
   input  logic [SEL_W-1:0]   sel,
   input  logic               cnt_en,
   input  logic               ld,
   input  logic [CNT_W-1:0]   ld_val,
   output logic [CNT_W-1:0]   cnt,
   output logic               wrap
);

   localparam int unsigned IDX_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
   localparam int unsigned PAD_N   = 1 << IDX_W;
   localparam bit          POW2    = (PAD_N == NUM_EVT);

   logic [PAD_N-1:0] evt_pad;
   logic             in_range;
   logic             hit;
   logic             inc;
   logic [CNT_W-1:0] cnt_q;

   assign evt_pad = PAD_N'(evt);

   // Range check: a bit test when the vector fills its index space, a compare otherwise.
   generate
      if (POW2) begin : g_range_bits
         assign in_range = (sel[SEL_W-1:IDX_W] == '0);
      end else begin : g_range_cmp
         assign in_range = (sel < SEL_W'(NUM_EVT));
      end
   endgenerate

   assign hit  = in_range & evt_pad[sel[IDX_W-1:0]];
   assign inc  = cnt_en & hit;
   assign wrap = inc & ~ld & (cnt_q == '1);

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= '0;
      else if (ld)  cnt_q <= ld_val;
      else if (inc) cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/dual_evcnt_unit.sv
module dual_evcnt_unit
   import evcnt_pkg::*;
#(
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned SEL_W      = 12,
   parameter int unsigned UP_SEL_LSB = 19,
   parameter int unsigned LO_SEL_LSB = 6,
   parameter int unsigned NUM_EVT    = 16,
   parameter int unsigned PARK_CODE  = 12'h220
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           priv,
   input  logic [NUM_EVT-1:0]   evt_pulse,
   input  logic                 reg_wr,
   input  logic                 reg_sel,
   input  logic [2*CNT_W-1:0]   reg_wdata,
   output logic [2*CNT_W-1:0]   reg_rdata,
   output logic                 ovf_irq
);

   localparam int unsigned REG_W = 2 * CNT_W;

   // Elaboration-time parameter checks.
   generate
      if (UP_FLAG_BIT >= REG_W) begin : g_bad_width
         $error("counter width too small to hold the flag bits");
      end
      if (LO_SEL_LSB <= HYP_EN_BIT || LO_SEL_LSB + SEL_W > UP_SEL_LSB) begin : g_bad_lo
         $error("lower select field overlaps its neighbours");
      end
      if (UP_SEL_LSB + SEL_W > LO_FLAG_BIT) begin : g_bad_up
         $error("upper select field overlaps the flag bits");
      end
      if (NUM_EVT < 1 || NUM_EVT > (1 << SEL_W)) begin : g_bad_evt
         $error("event vector size out of range");
      end
      if (PARK_CODE < NUM_EVT || PARK_CODE >= (1 << SEL_W)) begin : g_bad_park
         $error("park code must lie outside the event vector");
      end
   endgenerate

   logic                          irq_en, en_user, en_sup, en_hyp;
   logic [SEL_W-1:0]              sel_lo, sel_up;
   logic [N_LANES-1:0]            flag;
   logic [N_LANES-1:0]            wrap;
   logic [REG_W-1:0]              ctrl_image;
   logic [N_LANES-1:0][CNT_W-1:0] cnt_all;
   logic                          cnt_en;
   logic                          wr_ctrl, wr_cnt;
   priv_e                         priv_lvl;

   assign wr_ctrl  = reg_wr & ~reg_sel;
   assign wr_cnt   = reg_wr &  reg_sel;
   assign priv_lvl = priv_e'(priv);

   always_comb begin
      unique case (priv_lvl)
         PRIV_USER: cnt_en = en_user;
         PRIV_SUP:  cnt_en = en_sup;
         PRIV_HYP:  cnt_en = en_hyp;
         default:   cnt_en = 1'b0;
      endcase
   end

   evcnt_ctrl #(
      .REG_W      (REG_W),
      .SEL_W      (SEL_W),
      .UP_SEL_LSB (UP_SEL_LSB),
      .LO_SEL_LSB (LO_SEL_LSB)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_ctrl),
      .wdata   (reg_wdata),
      .ovf     (wrap),
      .irq_en  (irq_en),
      .en_user (en_user),
      .en_sup  (en_sup),
      .en_hyp  (en_hyp),
      .sel_lo  (sel_lo),
      .sel_up  (sel_up),
      .flag    (flag),
      .image   (ctrl_image)
   );

   generate
      for (genvar i = 0; i < N_LANES; i++) begin : g_lane
         logic [SEL_W-1:0] lane_sel;
         assign lane_sel = (i == LANE_UP) ? sel_up : sel_lo;

         evcnt_lane #(
            .CNT_W   (CNT_W),
            .SEL_W   (SEL_W),
            .NUM_EVT (NUM_EVT)
         ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_pulse),
            .sel    (lane_sel),
            .cnt_en (cnt_en),
            .ld     (wr_cnt),
            .ld_val (reg_wdata[i*CNT_W +: CNT_W]),
            .cnt    (cnt_all[i]),
            .wrap   (wrap[i])
         );
      end
   endgenerate

   assign reg_rdata = reg_sel ? cnt_all : ctrl_image;
   assign ovf_irq   = irq_en & (|flag);

endmodule

// File: rtl/evcnt_chk.sv
module evcnt_chk #(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned SEL_W   = 12,
   parameter int unsigned NUM_EVT = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_wr,
   input logic                 reg_sel,
   input logic [2*CNT_W-1:0]   reg_wdata,
   input logic [1:0][CNT_W-1:0] cnt_all,
   input logic [1:0]           flag,
   input logic [SEL_W-1:0]     sel_lo,
   input logic [SEL_W-1:0]     sel_up,
   input logic                 ovf_irq
);

   logic ld;
   assign ld = reg_wr & reg_sel;

   assert_step_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> (cnt_all[0] == $past(cnt_all[0]) || cnt_all[0] == $past(cnt_all[0]) + CNT_W'(1)));

   assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> (cnt_all[1] == $past(cnt_all[1]) || cnt_all[1] == $past(cnt_all[1]) + CNT_W'(1)));

   assert_park_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && sel_lo >= SEL_W'(NUM_EVT)) |=> $stable(cnt_all[0]));

   assert_park_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && sel_up >= SEL_W'(NUM_EVT)) |=> $stable(cnt_all[1]));

   assert_wrap_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[0]) |-> ($past(cnt_all[0]) == '1 && cnt_all[0] == '0));

   assert_wrap_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[1]) |-> ($past(cnt_all[1]) == '1 && cnt_all[1] == '0));

   assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cnt_all == $past(reg_wdata) && !$rose(flag[0]) && !$rose(flag[1])));

   assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> (flag != 2'b00));

endmodule

bind dual_evcnt_unit evcnt_chk #(
   .CNT_W   (CNT_W),
   .SEL_W   (SEL_W),
   .NUM_EVT (NUM_EVT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .cnt_all   (cnt_all),
   .flag      (flag),
   .sel_lo    (sel_lo),
   .sel_up    (sel_up),
   .ovf_irq   (ovf_irq)
);

// File: tb/sim_dual_evcnt_unit.sv
`timescale 1ns/1ps
module sim_dual_evcnt_unit;

   localparam int NEVT = 16;
   localparam logic [11:0] PARK = 12'h220;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  priv = 2'b00;
   logic [NEVT-1:0] evt = '0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        ovf_irq;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dual_evcnt_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .priv      (priv),
      .evt_pulse (evt),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .ovf_irq   (ovf_irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   // en = {hyp, user, sup}
   function automatic logic [63:0] mk(input bit irq, input bit [2:0] en,
                                      input logic [11:0] up, input logic [11:0] lo,
                                      input bit fu, input bit fl);
      logic [63:0] v;
      v = '0;
      v[0]     = irq;
      v[3:1]   = en;
      v[17:6]  = lo;
      v[30:19] = up;
      v[33]    = fl;
      v[34]    = fu;
      return v;
   endfunction

   task automatic wr_reg(input bit s, input logic [63:0] d);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      cyc();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input bit s, output logic [63:0] v);
      reg_sel = s;
      #1;
      v = reg_rdata;
   endtask

   task automatic pulse(input logic [NEVT-1:0] e, input int n);
      evt = e;
      repeat (n) cyc();
      evt = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired before the run ended");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      logic [11:0] code;
      logic [31:0] e32;
      bit          gate;
      int          periods [5] = '{1, 2, 3, 7, 100};

      @(negedge clk);
      repeat (3) cyc();
      rst_n = 1'b1;

      // R1 reset state
      rd(1'b0, v); chk("R1 control after reset", v, 64'h0);
      rd(1'b1, v); chk("R1 counters after reset", v, 64'h0);
      chk("R1 irq after reset", {63'h0, ovf_irq}, 64'h0);

      // R2 layout and load
      wr_reg(1'b1, 64'h0123_4567_89AB_CDEF);
      rd(1'b1, v); chk("R2 counter load readback", v, 64'h0123_4567_89AB_CDEF);
      priv = 2'b00;
      wr_reg(1'b0, mk(0, 3'b010, PARK, 12'd0, 0, 0));
      pulse(16'h0001, 1);
      rd(1'b1, v); chk("R2 lower half counts alone", v, 64'h0123_4567_89AB_CDF0);

      // R12 control read-back of defined fields only
      wr_reg(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(1'b0, v); chk("R12 control readback mask", v, mk(1, 3'b111, 12'hFFF, 12'hFFF, 0, 0));
      chk("R12 irq stays low with no flag", {63'h0, ovf_irq}, 64'h0);

      // R3/R4 privilege sweep
      for (int p = 0; p < 4; p++) begin
         for (int m = 0; m < 8; m++) begin
            priv = 2'(p);
            wr_reg(1'b0, mk(0, 3'(m), 12'd0, 12'd0, 0, 0));
            wr_reg(1'b1, 64'h0);
            pulse(16'h0001, 3);
            case (p)
               0:       gate = m[1];
               1:       gate = m[0];
               2:       gate = m[2];
               default: gate = 1'b0;
            endcase
            e32 = gate ? 32'd3 : 32'd0;
            rd(1'b1, v);
            chk((m == 0) ? "R4 all enables clear" : "R3 privilege gating", v, {e32, e32});
         end
      end

      // R5/R6 event select sweep on both lanes
      priv = 2'b00;
      for (int side = 0; side < 2; side++) begin
         for (int c = 0; c < NEVT + 3; c++) begin
            code = (c == NEVT + 2) ? PARK : 12'(c);
            if (side == 1) wr_reg(1'b0, mk(0, 3'b010, code, PARK, 0, 0));
            else           wr_reg(1'b0, mk(0, 3'b010, PARK, code, 0, 0));
            wr_reg(1'b1, 64'h0);
            for (int k = 0; k < NEVT; k++) pulse(NEVT'(1) << k, 1);
            pulse('1, 1);
            if (code < NEVT) pulse(~(NEVT'(1) << code), 1);
            e32 = (code < NEVT) ? 32'd2 : 32'd0;
            rd(1'b1, v);
            if (code < NEVT)
               chk("R5 event select count", v, (side == 1) ? {e32, 32'h0} : {32'h0, e32});
            else
               chk("R6 out-of-range or park code idle", v, 64'h0);
         end
      end

      // R7/R10 overflow of the upper counter
      wr_reg(1'b0, mk(1, 3'b010, 12'd0, PARK, 0, 0));
      wr_reg(1'b1, {32'hFFFF_FFFD, 32'd5});
      pulse(16'h0001, 2);
      rd(1'b1, v); chk("R7 no flag before wrap", v, {32'hFFFF_FFFF, 32'd5});
      chk("R7 irq low before wrap", {63'h0, ovf_irq}, 64'h0);
      pulse(16'h0001, 1);
      rd(1'b1, v); chk("R7 wrap to zero", v, {32'h0, 32'd5});
      rd(1'b0, v); chk("R7 only upper flag set", v, mk(1, 3'b010, 12'd0, PARK, 1, 0));
      chk("R10 irq with flag and enable", {63'h0, ovf_irq}, 64'h1);

      // R9 sticky clear semantics
      wr_reg(1'b0, mk(1, 3'b010, 12'd0, PARK, 1, 1));
      rd(1'b0, v); chk("R9 writing 1 keeps flags", v, mk(1, 3'b010, 12'd0, PARK, 1, 0));
      wr_reg(1'b0, mk(1, 3'b010, 12'd0, PARK, 0, 0));
      rd(1'b0, v); chk("R9 writing 0 clears flag", v, mk(1, 3'b010, 12'd0, PARK, 0, 0));
      chk("R9 irq low after clear", {63'h0, ovf_irq}, 64'h0);

      // R10 interrupt enable gating
      wr_reg(1'b0, mk(0, 3'b010, 12'd0, PARK, 0, 0));
      wr_reg(1'b1, {32'hFFFF_FFFF, 32'd0});
      pulse(16'h0001, 1);
      rd(1'b0, v); chk("R10 flag set with irq disabled", v, mk(0, 3'b010, 12'd0, PARK, 1, 0));
      chk("R10 irq masked", {63'h0, ovf_irq}, 64'h0);
      wr_reg(1'b0, mk(1, 3'b010, PARK, PARK, 1, 0));
      chk("R10 irq after enabling", {63'h0, ovf_irq}, 64'h1);
      wr_reg(1'b0, mk(0, 3'b010, PARK, PARK, 0, 0));

      // R8 preload with negative period on the lower counter
      foreach (periods[i]) begin
         wr_reg(1'b0, mk(1, 3'b010, PARK, 12'd0, 0, 0));
         wr_reg(1'b1, {32'h0, -32'(periods[i])});
         if (periods[i] > 1) pulse(16'h0001, periods[i] - 1);
         chk("R8 no overflow before period", {63'h0, ovf_irq}, 64'h0);
         pulse(16'h0001, 1);
         rd(1'b0, v); chk("R8 lower flag after period", v, mk(1, 3'b010, PARK, 12'd0, 0, 1));
         chk("R8 irq after period", {63'h0, ovf_irq}, 64'h1);
      end
      wr_reg(1'b0, mk(0, 3'b010, 12'd0, 12'd0, 0, 0));

      // R11 write collides with increment at the wrap point
      wr_reg(1'b1, {32'hFFFF_FFFF, 32'hFFFF_FFFF});
      evt = 16'h0001;
      wr_reg(1'b1, {32'h1234_5678, 32'h9ABC_DEF0});
      evt = '0;
      rd(1'b1, v); chk("R11 write wins over increment", v, {32'h1234_5678, 32'h9ABC_DEF0});
      rd(1'b0, v); chk("R11 no flag from dropped increment", v, mk(0, 3'b010, 12'd0, 12'd0, 0, 0));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule